// File: doc/BRIEF.md
# Control-Pin Start-Up Mode Detector and Shutdown Timer

This block watches one synchronized logic control pin. From that pin alone it decides whether the device is enabled, and which dimming mode applies for the current power-on session. The two modes are the default PWM mode and a single-wire digital mode. A microsecond tick input sets the time base. Every duration in the block is counted in ticks, and nothing is counted in clock cycles.

When the device is shut down, a high level on the pin enables it and opens a detection window. A low pulse that begins after a short settling delay, and that lasts long enough before the window closes, selects digital mode at once. If the window closes without such a pulse, PWM mode is selected. Either choice is then locked. It can change only after the pin has been held low long enough to shut the device down, and the device has then been enabled again. A long low level always shuts the device down, whether or not detection is still in progress.

Top module: `ctrl_mode_detect`

## Requirements
- R1: After reset, `enable`, `digital_mode` and `mode_locked` are all 0.
- R2: While shut down, a high level on `ctrl_pin` raises `enable` within two clock cycles. It enters the detection phase with `mode_locked` = 0 and `digital_mode` = 0, and the window count starts from zero.
- R3: If `ctrl_pin` stays high for the whole detection window of WIN_US (1000) ticks, `mode_locked` becomes 1 and `digital_mode` stays 0, meaning PWM.
- R4: A low level that begins at least DELAY_US (100) ticks into the window and lasts more than DETECT_US (260) ticks, with that length reached before the window ends, sets `digital_mode` = 1 and `mode_locked` = 1 without waiting for the window to end. A shorter low pulse has no effect.
- R5: A low level that begins before DELAY_US ticks have elapsed does not qualify, however long it lasts short of shutdown. The window then ends in PWM.
- R6: A low level that reaches DETECT_US ticks only after the window has ended does not select digital mode.
- R7: Once `mode_locked` is 1, `digital_mode` does not change while `enable` stays 1.
- R8: A low level on `ctrl_pin` lasting more than SHDN_US (2500) ticks clears `enable`, `mode_locked` and `digital_mode`. A low of 2400 ticks does not.
- R9: Shutdown takes priority over detection. A long low that starts inside the window ends with the device shut down and unlocked.
- R10: Time advances only on cycles where `tick_us` is 1. Without ticks, no low level, however long, causes shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| ctrl_pin | input | 1 | Control pin, already synchronized to `clk` |
| enable | output | 1 | Device enabled |
| digital_mode | output | 1 | 1 = single-wire digital mode, 0 = PWM mode |
| mode_locked | output | 1 | Mode decision made for this session |

## Verification
The assertions assume that `ctrl_pin` is already synchronized and changes only between clock edges. They also assume the tick is a single-cycle pulse, so a pin sampled high can never be read as part of a shutdown low. The bench drives the pin on falling clock edges and holds the tick high on every cycle, except in the scenario that gates it off. Each duration is then an exact tick count. Pulse lengths keep tens of ticks of margin from every threshold, so a one-cycle register delay cannot flip any expected result.

// File: rtl/ctrl_mode_detect.sv
module ctrl_mode_detect #(
  parameter int SHDN_US   = 2500,
  parameter int DELAY_US  = 100,
  parameter int DETECT_US = 260,
  parameter int WIN_US    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic ctrl_pin,
  output logic enable,
  output logic digital_mode,
  output logic mode_locked
);
  localparam int CW = $clog2(SHDN_US + WIN_US + 2);

  typedef enum logic [1:0] {ST_OFF, ST_DETECT, ST_RUN} st_t;

  st_t           st;
  logic          pin_q, qual, dig;
  logic [CW-1:0] low_cnt, win_cnt;

  wire fall   = pin_q & ~ctrl_pin;
  wire shdn   = (st != ST_OFF) && !ctrl_pin && (low_cnt > CW'(SHDN_US));
  wire hit    = (st == ST_DETECT) && !ctrl_pin && qual &&
                (low_cnt > CW'(DETECT_US)) && (win_cnt < CW'(WIN_US));
  wire expire = (st == ST_DETECT) && (win_cnt >= CW'(WIN_US));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      low_cnt <= '0;
    end else begin
      pin_q <= ctrl_pin;
      if (ctrl_pin)
        low_cnt <= '0;
      else if (tick_us && low_cnt <= CW'(SHDN_US))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      qual    <= 1'b0;
    end else if (st != ST_DETECT) begin
      win_cnt <= '0;
      qual    <= 1'b0;
    end else begin
      if (tick_us && win_cnt < CW'(WIN_US))
        win_cnt <= win_cnt + 1'b1;
      if (fall)
        qual <= (win_cnt >= CW'(DELAY_US));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      dig <= 1'b0;
    end else begin
      case (st)
        ST_OFF: if (ctrl_pin) begin
          st  <= ST_DETECT;
          dig <= 1'b0;
        end
        ST_DETECT: begin
          if (shdn) begin
            st  <= ST_OFF;
            dig <= 1'b0;
          end else if (hit) begin
            st  <= ST_RUN;
            dig <= 1'b1;
          end else if (expire) begin
            st  <= ST_RUN;
            dig <= 1'b0;
          end
        end
        ST_RUN: if (shdn) begin
          st  <= ST_OFF;
          dig <= 1'b0;
        end
        default: begin
          st  <= ST_OFF;
          dig <= 1'b0;
        end
      endcase
    end
  end

  assign enable       = (st != ST_OFF);
  assign mode_locked  = (st == ST_RUN);
  assign digital_mode = dig;
endmodule

module ctrl_mode_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_us,
  input logic ctrl_pin,
  input logic enable,
  input logic digital_mode,
  input logic mode_locked
);
  AST_OFF_IS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!mode_locked && !digital_mode)); // R8
  AST_DIGITAL_IS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    digital_mode |-> (mode_locked && enable)); // R4
  AST_ENABLE_STARTS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (!mode_locked && !digital_mode)); // R2
  AST_LOCK_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_locked && enable) |=> (!enable || (mode_locked && digital_mode == $past(digital_mode)))); // R7
  AST_HIGH_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ctrl_pin) |=> enable); // R8
  AST_HIGH_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && ctrl_pin) |=> enable); // R2
endmodule

bind ctrl_mode_detect ctrl_mode_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ctrl_pin(ctrl_pin),
  .enable(enable), .digital_mode(digital_mode), .mode_locked(mode_locked)
);

// File: tb/ctrl_mode_detect_tb.sv
module ctrl_mode_detect_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic ctrl_pin = 1'b0;
  logic enable, digital_mode, mode_locked;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ctrl_mode_detect u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ctrl_pin(ctrl_pin),
    .enable(enable), .digital_mode(digital_mode), .mode_locked(mode_locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic hold(input logic lvl, input int n);
    ctrl_pin = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {enable, mode_locked, digital_mode};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {en,lock,dig} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic power_down();
    hold(1'b0, 2600);
  endtask

  task automatic t_reset();
    check("R1", 3'b000);
  endtask

  task automatic t_enable();
    hold(1'b1, 2);
    check("R2", 3'b100);
  endtask

  task automatic t_pwm_default();
    hold(1'b1, 1100);
    check("R3", 3'b110);
  endtask

  task automatic t_digital();
    power_down();
    check("R8", 3'b000);
    hold(1'b1, 150);
    hold(1'b0, 200);
    hold(1'b1, 20);
    check("R4 short low", 3'b100);
    hold(1'b0, 250);
    check("R4 before detect", 3'b100);
    hold(1'b0, 30);
    check("R4 selected", 3'b111);
    hold(1'b1, 50);
    check("R4 after", 3'b111);
  endtask

  task automatic t_lock_digital();
    hold(1'b0, 400);
    hold(1'b1, 2000);
    check("R7 digital kept", 3'b111);
  endtask

  task automatic t_early();
    power_down();
    hold(1'b1, 50);
    hold(1'b0, 320);
    hold(1'b1, 20);
    check("R5 no select", 3'b100);
    hold(1'b1, 700);
    check("R5 ends pwm", 3'b110);
  endtask

  task automatic t_lock_pwm();
    hold(1'b1, 100);
    hold(1'b0, 400);
    hold(1'b1, 100);
    check("R7 pwm kept", 3'b110);
  endtask

  task automatic t_late();
    power_down();
    hold(1'b1, 800);
    hold(1'b0, 300);
    check("R6 pwm", 3'b110);
    hold(1'b1, 50);
    check("R6 after", 3'b110);
  endtask

  task automatic t_shutdown_edge();
    hold(1'b0, 2400);
    check("R8 2400 low", 3'b110);
    hold(1'b0, 200);
    check("R8 shut", 3'b000);
    hold(1'b1, 2);
    check("R2 restart", 3'b100);
  endtask

  task automatic t_priority();
    hold(1'b1, 200);
    hold(1'b0, 400);
    check("R9 digital first", 3'b111);
    hold(1'b0, 2200);
    check("R9 shutdown", 3'b000);
    hold(1'b1, 1100);
    check("R9 fresh pwm", 3'b110);
  endtask

  task automatic t_no_tick();
    tick_us = 1'b0;
    hold(1'b0, 3000);
    check("R10 frozen", 3'b110);
    tick_us = 1'b1;
    hold(1'b0, 2600);
    check("R10 resumes", 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pwm_default();
    t_digital();
    t_lock_digital();
    t_early();
    t_lock_pwm();
    t_late();
    t_shutdown_edge();
    t_priority();
    t_no_tick();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule